// File: doc/BRIEF.md
# Four-Input Event-Preserving Stream Merger

The block combines four independent word streams into a single output stream. Each word carries 21 data bits and two flags: one flags the last word of a packet, the other marks the close of an event. Every input has its own receive queue, which accepts a word on each cycle the source presents one. When the queue is nearly full it raises a per-input hold line back to the source. One clock domain is assumed throughout.

Packets are granted in order of arrival. An input that has been granted keeps the output until the word that ends its packet, so packets are never interleaved. End-of-event words on the inputs are markers: they are absorbed and not forwarded. Once an input has delivered its marker, its later packets wait. When all four inputs have delivered theirs, the block emits one combined end-of-event word and re-arms every input for the next event. A downstream hold line stalls the registered output.

Top module: `stream_merger4`

## Requirements
- R1: During reset and on the first cycle after it, outValid is 0 and every inHold bit is 0.
- R2: Every forwarded word leaves with its data and outEndPkt equal to the input word. The words of one packet leave back to back, with no word from another input between them. Each input's packets leave in the order they arrived.
- R3: Among waiting packets, the one whose first word reached the head of its queue in an earlier cycle is granted first.
- R4: Packets whose first words reach the heads of their queues in the same cycle are granted in ascending input index.
- R5: An input word with inEndEvt=1 is an end-of-event marker. It is never forwarded, and its data and inEndPkt bits are ignored.
- R6: The combined end-of-event word has outEndEvt=1, outEndPkt=0 and outData=0. It is emitted only after every input has delivered its marker for the event and all data words of that event have left.
- R7: After an input delivers its marker, its later packets are held back until the combined end-of-event word has left, even if other inputs' packets arrive later.
- R8: inHold for an input is 1 exactly when its queue holds at least DEPTH-SLACK words (12 with the defaults DEPTH=16, SLACK=4), and it returns to 0 once the queue drains below that level.
- R9: While outValid and outHold are both 1, outValid, outData, outEndPkt and outEndEvt do not change on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 4 | Per-input word strobe |
| inData | input | 4x21 | Per-input data word |
| inEndPkt | input | 4 | Per-input last-word-of-packet flag |
| inEndEvt | input | 4 | Per-input end-of-event marker flag |
| inHold | output | 4 | Per-input almost-full hold toward the source |
| outValid | output | 1 | Output word valid |
| outData | output | 21 | Output data word |
| outEndPkt | output | 1 | Output last-word-of-packet flag |
| outEndEvt | output | 1 | Output combined end-of-event flag |
| outHold | input | 1 | Downstream stall request |

## Verification
A lock that is released too early or held on the wrong input shows up at the ports on the next accepted word. That word carries a source tag from a different input while a packet is still open. A bad age bit swaps the order of two waiting packets, and the first word to leave already reveals it. A lost or stuck per-input event flag shows up in one of two ways. Either a combined end-of-event word appears before some input's marker or data, or the masked packets never leave. The second case is caught when the drained stream ends with words still expected. A wrong occupancy count shows up on inHold as soon as the threshold write lands.

// File: rtl/merger_pkg.sv
package merger_pkg;
  localparam int N_IN   = 4;
  localparam int DATA_W = 21;
  localparam int SEL_W  = $clog2(N_IN);

  typedef struct packed {
    logic              ee;
    logic              ep;
    logic [DATA_W-1:0] data;
  } word_t;

  // Strobes from control to datapath, one bundle per cycle.
  typedef struct packed {
    logic [N_IN-1:0]  popData;  // dequeue a data word for the output
    logic [N_IN-1:0]  popMark;  // absorb an end-of-event marker
    logic             load;     // load selected head into output register
    logic             loadEe;   // load the combined end-of-event word
    logic [SEL_W-1:0] sel;      // input feeding the output register
  } ctrl_strobe_t;
endpackage

// File: rtl/merger_fifo.sv
module merger_fifo
  import merger_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SLACK = 4
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  wrEn,
  input  word_t wrWord,
  input  logic  rdEn,
  output word_t headWord,
  output logic  notEmpty,
  output logic  almostFull
);
  localparam int AW     = $clog2(DEPTH);
  localparam int CW     = AW + 1;
  localparam int THRESH = DEPTH - SLACK;

  word_t mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic wrOk, rdOk;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wrOk       = wrEn && (count != CW'(DEPTH));
  assign rdOk       = rdEn && (count != '0);
  assign headWord   = mem[rdPtr];
  assign notEmpty   = (count != '0);
  assign almostFull = (count >= CW'(THRESH));

  always_ff @(posedge clk) begin
    if (wrOk) mem[wrPtr] <= wrWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrOk) wrPtr <= bump(wrPtr);
      if (rdOk) rdPtr <= bump(rdPtr);
      case ({wrOk, rdOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/merger_datapath.sv
module merger_datapath
  import merger_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SLACK = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [N_IN-1:0]              inValid,
  input  logic [N_IN-1:0][DATA_W-1:0]  inData,
  input  logic [N_IN-1:0]              inEndPkt,
  input  logic [N_IN-1:0]              inEndEvt,
  output logic [N_IN-1:0]              inHold,
  input  ctrl_strobe_t                 strobe,
  input  logic                         outHold,
  output logic [N_IN-1:0]              headValid,
  output logic [N_IN-1:0]              headEp,
  output logic [N_IN-1:0]              headEe,
  output logic                         outValid,
  output logic [DATA_W-1:0]            outData,
  output logic                         outEndPkt,
  output logic                         outEndEvt
);
  word_t head [N_IN];
  word_t outWord;
  word_t eeWord;
  logic  outValidQ;

  assign eeWord = '{ee: 1'b1, ep: 1'b0, data: '0};

  for (genvar g = 0; g < N_IN; g++) begin : g_lane
    word_t wrWord;
    assign wrWord = '{ee: inEndEvt[g], ep: inEndPkt[g], data: inData[g]};

    merger_fifo #(.DEPTH(DEPTH), .SLACK(SLACK)) u_fifo (
      .clk        (clk),
      .rstN       (rstN),
      .wrEn       (inValid[g]),
      .wrWord     (wrWord),
      .rdEn       (strobe.popData[g] | strobe.popMark[g]),
      .headWord   (head[g]),
      .notEmpty   (headValid[g]),
      .almostFull (inHold[g])
    );

    assign headEp[g] = head[g].ep;
    assign headEe[g] = head[g].ee;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValidQ <= 1'b0;
      outWord   <= '0;
    end else if (strobe.loadEe) begin
      outValidQ <= 1'b1;
      outWord   <= eeWord;
    end else if (strobe.load) begin
      outValidQ <= 1'b1;
      outWord   <= '{ee: 1'b0, ep: head[strobe.sel].ep, data: head[strobe.sel].data};
    end else if (!outHold) begin
      outValidQ <= 1'b0;
    end
  end

  assign outValid  = outValidQ;
  assign outData   = outWord.data;
  assign outEndPkt = outWord.ep;
  assign outEndEvt = outWord.ee;
endmodule

// File: rtl/merger_ctrl.sv
module merger_ctrl
  import merger_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [N_IN-1:0] headValid,
  input  logic [N_IN-1:0] headEp,
  input  logic [N_IN-1:0] headEe,
  input  logic            outValid,
  input  logic            outHold,
  output ctrl_strobe_t    strobe
);
  logic                       busy;
  logic [SEL_W-1:0]           owner;
  logic [N_IN-1:0]            eeSeen, reqPrev, startPop;
  logic [N_IN-1:0][N_IN-1:0]  older, olderNxt;   // older[i][j]: i waited longer than j
  logic [N_IN-1:0]            req, newReq, oldReq, win, ownerMask;
  logic                       outFree, allSeen, anyWin;
  logic [SEL_W-1:0]           winIdx;

  always_comb begin
    ownerMask        = '0;
    ownerMask[owner] = busy;
  end

  assign outFree = !outValid || !outHold;
  assign allSeen = &eeSeen;
  // A non-owner head always sits on a packet boundary.
  assign req     = headValid & ~headEe & ~eeSeen & ~ownerMask;
  assign newReq  = req & (~reqPrev | startPop);
  assign oldReq  = req & ~newReq;

  // Age matrix update: a fresh request is younger than every standing one;
  // fresh requests in the same cycle rank by index.
  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      for (int j = 0; j < N_IN; j++) begin
        if (i == j)          olderNxt[i][j] = 1'b0;
        else if (newReq[i])  olderNxt[i][j] = !oldReq[j] && !(newReq[j] && (j < i));
        else if (newReq[j])  olderNxt[i][j] = 1'b1;
        else                 olderNxt[i][j] = older[i][j];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      win[i] = req[i];
      for (int j = 0; j < N_IN; j++) begin
        if (j != i && req[j] && !olderNxt[i][j]) win[i] = 1'b0;
      end
    end
  end

  always_comb begin
    winIdx = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (win[i]) winIdx = SEL_W'(i);
    end
  end

  assign anyWin = |win;

  always_comb begin
    strobe         = '0;
    strobe.popMark = headValid & headEe & ~eeSeen & ~ownerMask;
    if (outFree) begin
      if (busy) begin
        if (headValid[owner]) begin
          strobe.popData[owner] = 1'b1;
          strobe.load           = 1'b1;
          strobe.sel            = owner;
        end
      end else if (allSeen) begin
        strobe.loadEe = 1'b1;
      end else if (anyWin) begin
        strobe.popData[winIdx] = 1'b1;
        strobe.load            = 1'b1;
        strobe.sel             = winIdx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      owner    <= '0;
      eeSeen   <= '0;
      reqPrev  <= '0;
      startPop <= '0;
      older    <= '0;
    end else begin
      older    <= olderNxt;
      reqPrev  <= req;
      startPop <= busy ? '0 : strobe.popData;
      if (strobe.load) begin
        owner <= strobe.sel;
        busy  <= !headEp[strobe.sel];
      end
      eeSeen <= strobe.loadEe ? '0 : (eeSeen | strobe.popMark);
    end
  end
endmodule

// File: rtl/stream_merger4.sv
module stream_merger4
  import merger_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SLACK = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [N_IN-1:0]             inValid,
  input  logic [N_IN-1:0][DATA_W-1:0] inData,
  input  logic [N_IN-1:0]             inEndPkt,
  input  logic [N_IN-1:0]             inEndEvt,
  output logic [N_IN-1:0]             inHold,
  output logic                        outValid,
  output logic [DATA_W-1:0]           outData,
  output logic                        outEndPkt,
  output logic                        outEndEvt,
  input  logic                        outHold
);
  ctrl_strobe_t    strobe;
  logic [N_IN-1:0] headValid, headEp, headEe;

  merger_datapath #(.DEPTH(DEPTH), .SLACK(SLACK)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inData    (inData),
    .inEndPkt  (inEndPkt),
    .inEndEvt  (inEndEvt),
    .inHold    (inHold),
    .strobe    (strobe),
    .outHold   (outHold),
    .headValid (headValid),
    .headEp    (headEp),
    .headEe    (headEe),
    .outValid  (outValid),
    .outData   (outData),
    .outEndPkt (outEndPkt),
    .outEndEvt (outEndEvt)
  );

  merger_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .headValid (headValid),
    .headEp    (headEp),
    .headEe    (headEe),
    .outValid  (outValid),
    .outHold   (outHold),
    .strobe    (strobe)
  );
endmodule

// File: rtl/merger_checker.sv
module merger_checker
  import merger_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic [N_IN-1:0]     inValid,
  input logic [N_IN-1:0]     inEndEvt,
  input logic [N_IN-1:0]     inHold,
  input logic                outValid,
  input logic [DATA_W-1:0]   outData,
  input logic                outEndPkt,
  input logic                outEndEvt,
  input logic                outHold,
  input ctrl_strobe_t        strobe
);
  logic [7:0] eeInCnt [N_IN];
  logic [7:0] eeOutCnt;
  logic       allOwed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N_IN; i++) eeInCnt[i] <= '0;
      eeOutCnt <= '0;
    end else begin
      for (int i = 0; i < N_IN; i++) begin
        if (inValid[i] && inEndEvt[i]) eeInCnt[i] <= eeInCnt[i] + 1'b1;
      end
      if (outValid && outEndEvt && !outHold) eeOutCnt <= eeOutCnt + 1'b1;
    end
  end

  always_comb begin
    allOwed = 1'b1;
    for (int i = 0; i < N_IN; i++) begin
      if (eeInCnt[i] == eeOutCnt) allOwed = 1'b0;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) !rstN |=> !outValid);

  a_r9_stall_stable: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outHold |=> outValid && $stable(outData) && $stable(outEndPkt) && $stable(outEndEvt));

  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.popData) && (!strobe.load || strobe.popData[strobe.sel]));

  a_r5_marker_apart: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.popMark & strobe.popData) == '0);

  a_r6_ee_format: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outEndEvt |-> outData == '0 && !outEndPkt);

  a_r6_ee_all_inputs: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outEndEvt |-> allOwed);

  a_r6_ee_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEe |-> !strobe.load && strobe.popData == '0);

  for (genvar g = 0; g < N_IN; g++) begin : g_hold
    a_r8_hold_cause: assert property (@(posedge clk) disable iff (!rstN)
      $rose(inHold[g]) |-> $past(inValid[g]));
  end
endmodule

bind stream_merger4 merger_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inEndEvt  (inEndEvt),
  .inHold    (inHold),
  .outValid  (outValid),
  .outData   (outData),
  .outEndPkt (outEndPkt),
  .outEndEvt (outEndEvt),
  .outHold   (outHold),
  .strobe    (strobe)
);

// File: tb/tb_stream_merger4.sv
`timescale 1ns/1ps
module tb_stream_merger4;
  localparam int NEVT = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]       inValid, inEndPkt, inEndEvt, inHold;
  logic [3:0][20:0] inData;
  logic             outValid, outEndPkt, outEndEvt, outHold;
  logic [20:0]      outData;

  logic        drvValid [4];
  logic [20:0] drvData  [4];
  logic        drvEp    [4];
  logic        drvEe    [4];

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      inValid[i]  = drvValid[i];
      inData[i]   = drvData[i];
      inEndPkt[i] = drvEp[i];
      inEndEvt[i] = drvEe[i];
    end
  end

  stream_merger4 dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inEndPkt(inEndPkt), .inEndEvt(inEndEvt), .inHold(inHold),
    .outValid(outValid), .outData(outData), .outEndPkt(outEndPkt),
    .outEndEvt(outEndEvt), .outHold(outHold)
  );

  typedef struct { logic [20:0] data; logic ep; int evt; } exp_t;
  exp_t        expQ [4][$];
  int          eeSent [4];
  int          pend [4][64];
  int          seqCnt [4];
  int          evtOut = 0;
  int          curOwner = -1;
  int          logTag [$];
  int          checks = 0;
  int          errors = 0;
  bit          rndDone = 0;
  bit          heldPrev = 0;
  logic [22:0] heldWord;

  task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  task automatic sendWord(input int i, input logic [20:0] d, input bit ep, input bit ee, input bit heed);
    while (heed && inHold[i]) begin @(posedge clk); #1; end
    drvValid[i] = 1'b1; drvData[i] = d; drvEp[i] = ep; drvEe[i] = ee;
    if (ee) eeSent[i]++;
    else begin
      exp_t e;
      e.data = d; e.ep = ep; e.evt = eeSent[i];
      expQ[i].push_back(e);
      pend[i][eeSent[i]]++;
    end
    @(posedge clk); #1;
    drvValid[i] = 1'b0;
  endtask

  task automatic sendPkt(input int i, input int len, input bit heed);
    for (int k = 0; k < len; k++) begin
      seqCnt[i]++;
      sendWord(i, {i[1:0], seqCnt[i][18:0]}, k == len - 1, 1'b0, heed);
    end
  endtask

  task automatic runInput(input int i);
    for (int e = 0; e < NEVT; e++) begin
      int np;
      np = $urandom_range(0, 3);
      for (int p = 0; p < np; p++) begin
        repeat ($urandom_range(0, 2)) begin @(posedge clk); #1; end
        sendPkt(i, $urandom_range(1, 4), 1'b1);
      end
      sendWord(i, 21'h0, 1'($urandom_range(0, 1)), 1'b1, 1'b1);
    end
  endtask

  function automatic int tagAt(input int k);
    if (k >= logTag.size()) return -1;
    return logTag[k];
  endfunction

  task automatic waitCyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // Output monitor, away from the active edge.
  always @(negedge clk) begin
    if (rstN) begin
      if (heldPrev)
        chk(outValid && {outEndEvt, outEndPkt, outData} == heldWord,
            "R9 stalled word changed", {outEndEvt, outEndPkt, outData}, heldWord);
      heldPrev = outValid && outHold;
      heldWord = {outEndEvt, outEndPkt, outData};
      if (outValid && !outHold) begin
        if (outEndEvt) begin
          logTag.push_back(4);
          chk(outData == 0 && !outEndPkt, "R6 end-event word format", outData, 0);
          chk(curOwner < 0, "R6 end-event inside packet", curOwner, -1);
          for (int i = 0; i < 4; i++) begin
            chk(eeSent[i] > evtOut, "R6 end-event before input marker", eeSent[i], evtOut + 1);
            chk(pend[i][evtOut] == 0, "R6 event data left behind", pend[i][evtOut], 0);
          end
          evtOut++;
        end else begin
          int src;
          src = int'(outData[20:19]);
          logTag.push_back(src);
          if (expQ[src].size() == 0) chk(1'b0, "R2 unexpected word", outData, 0);
          else begin
            exp_t e;
            e = expQ[src].pop_front();
            chk(e.data == outData && e.ep == outEndPkt, "R2 word content or order", outData, e.data);
            chk(e.evt == evtOut, "R7 word left in wrong event", evtOut, e.evt);
            pend[src][e.evt]--;
          end
          if (curOwner >= 0) chk(src == curOwner, "R2 packet interleaved", src, curOwner);
          curOwner = outEndPkt ? -1 : src;
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    checks++; errors++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) begin
      drvValid[i] = 0; drvData[i] = '0; drvEp[i] = 0; drvEe[i] = 0;
      eeSent[i] = 0; seqCnt[i] = 0;
    end
    outHold = 1'b0;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(outValid == 1'b0, "R1 outValid in reset", outValid, 0);
    chk(inHold == 4'b0, "R1 inHold in reset", inHold, 0);
    @(posedge clk); #1; rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    chk(inHold == 4'b0, "R1 inHold after reset", inHold, 0);
    @(posedge clk); #1;

    // R3: earlier head wins (input 2 before input 0)
    outHold = 1'b1;
    base = logTag.size();
    sendPkt(3, 1, 1'b0);
    sendPkt(2, 2, 1'b0);
    sendPkt(0, 1, 1'b0);
    waitCyc(4);
    outHold = 1'b0;
    waitCyc(10);
    chk(tagAt(base) == 3, "R3 first packet", tagAt(base), 3);
    chk(tagAt(base + 1) == 2 && tagAt(base + 2) == 2, "R3 older packet next", tagAt(base + 1), 2);
    chk(tagAt(base + 3) == 0, "R3 younger packet last", tagAt(base + 3), 0);

    // R4: same-cycle arrivals by index
    outHold = 1'b1;
    base = logTag.size();
    sendPkt(0, 1, 1'b0);
    fork
      sendPkt(3, 1, 1'b0);
      sendPkt(1, 1, 1'b0);
    join
    waitCyc(4);
    outHold = 1'b0;
    waitCyc(10);
    chk(tagAt(base + 1) == 1, "R4 lower index first", tagAt(base + 1), 1);
    chk(tagAt(base + 2) == 3, "R4 higher index second", tagAt(base + 2), 3);

    // R8: almost-full threshold (first word moves to the output register)
    outHold = 1'b1;
    for (int k = 0; k < 12; k++) begin
      seqCnt[0]++;
      sendWord(0, {2'd0, seqCnt[0][18:0]}, 1'b0, 1'b0, 1'b0);
    end
    chk(inHold[0] == 1'b0, "R8 hold below threshold", inHold[0], 0);
    seqCnt[0]++;
    sendWord(0, {2'd0, seqCnt[0][18:0]}, 1'b0, 1'b0, 1'b0);
    chk(inHold[0] == 1'b1, "R8 hold at threshold", inHold[0], 1);
    seqCnt[0]++;
    sendWord(0, {2'd0, seqCnt[0][18:0]}, 1'b1, 1'b0, 1'b0);
    outHold = 1'b0;
    waitCyc(25);
    chk(inHold[0] == 1'b0, "R8 hold released after drain", inHold[0], 0);

    // R5, R6, R7: marker absorbed, early input masked, combined end-event
    base = logTag.size();
    sendWord(0, 21'h155555, 1'b1, 1'b1, 1'b1);
    sendPkt(0, 2, 1'b1);
    waitCyc(5);
    sendPkt(1, 1, 1'b1);
    sendWord(1, 21'h0, 1'b0, 1'b1, 1'b1);
    sendWord(2, 21'h0, 1'b0, 1'b1, 1'b1);
    sendWord(3, 21'h0, 1'b0, 1'b1, 1'b1);
    waitCyc(20);
    chk(tagAt(base) == 1, "R7 later input passes masked one", tagAt(base), 1);
    chk(tagAt(base + 1) == 4, "R6 combined end-event position", tagAt(base + 1), 4);
    chk(tagAt(base + 2) == 0 && tagAt(base + 3) == 0, "R7 masked input after re-arm", tagAt(base + 2), 0);
    chk(logTag.size() == base + 4, "R5 marker not forwarded", logTag.size() - base, 4);

    // Random traffic with random downstream stalls
    fork
      begin
        fork
          runInput(0);
          runInput(1);
          runInput(2);
          runInput(3);
        join
        rndDone = 1;
      end
      begin
        while (!rndDone) begin
          @(posedge clk); #1;
          outHold = ($urandom_range(0, 3) == 0);
        end
      end
    join
    outHold = 1'b0;
    waitCyc(300);
    for (int i = 0; i < 4; i++)
      chk(expQ[i].size() == 0, "R2 words never delivered", expQ[i].size(), 0);
    chk(evtOut == NEVT + 1, "R6 combined end-event count", evtOut, NEVT + 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule